// File: doc/BRIEF.md
# Flag-Conditioned Short Branch Unit

This block executes two one-word conditional branches inside an 8-bit microcontroller core. One branch is taken when the overflow flag is clear. The other is taken when the zero flag is clear. The block owns the program counter. It sequences a four-phase instruction cycle, and a simple input stands in for the fetched instruction word. Both branches share one decoder and one adder. That adder forms the target from the address of the instruction and a doubled signed byte offset.

The surrounding core presents a word and the two flags while the block is in its first phase. The block then works through the cycle:

- It decodes the word.
- It latches the literal offset.
- It decides the branch and forms the target.
- At the close of the fourth phase, it writes the counter.

A taken branch is followed by one full instruction cycle of idling, during which any presented word is ignored. A word that is neither branch is flagged as not belonging to this block, and the counter is left alone.

Top module: `cbr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `pc_out`, `phase_out`, `idle_out`, `taken_out` and `foreign_out` to 0.
- R2: Out of reset, `phase_out` advances by one on every clock, in the order 0,1,2,3,0 (0 = decode, 1 = literal read, 2 = process, 3 = counter write).
- R3: A word whose upper byte is 0xE5 is the overflow-clear branch. It is taken only when `flag_ov`, sampled in phase 0, is 0. `flag_z` has no effect on it.
- R4: A word whose upper byte is 0xE1 is the zero-clear branch. It is taken only when `flag_z`, sampled in phase 0, is 0. `flag_ov` has no effect on it.
- R5: For a taken branch, the counter becomes its own address + 2 + 2·n, wrapped modulo 2^21. Here n is the lower byte of the word read as a two's-complement value (-128..127). The new value appears after the phase-3 clock edge, and `taken_out` is 1 from the phase-2 edge.
- R6: For a branch that is not taken, the counter becomes its own address + 2 and `taken_out` is 0.
- R7: After a taken branch, `idle_out` is 1 for exactly one four-phase cycle. During that cycle the presented word and flags are ignored and the counter does not change. After it, `taken_out` and `foreign_out` are 0.
- R8: A word matching neither upper byte sets `foreign_out` to 1 from the phase-1 edge, and the counter keeps its value.
- R9: Bit 0 of `pc_out` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 16 | Fetched instruction word, sampled in phase 0 |
| flag_ov | input | 1 | Overflow status flag, sampled in phase 0 |
| flag_z | input | 1 | Zero status flag, sampled in phase 0 |
| pc_out | output | 21 | Byte-addressed program counter |
| phase_out | output | 2 | Current phase of the instruction cycle |
| idle_out | output | 1 | High during the idle cycle after a taken branch |
| taken_out | output | 1 | Decision of the branch under execution |
| foreign_out | output | 1 | Word under execution is not one of the two branches |

## Verification
The bench targets the extremes of the offset:

- n = -128 taken at address 0. A design that treats the offset as unsigned, or forgets to double it, lands far from 0x1FFF02.
- n = +127 from near the top of the space. A design that keeps a carry beyond 21 bits does not wrap to 0x000002.

Each branch is also run with the opposite flag toggled. A design that wires the wrong flag to a condition takes or skips the branch wrongly.

The idle cycle is presented with a word that would otherwise be taken. A design that does not suppress it moves the counter.

A near-miss upper byte (0xE3) is offered. A sloppy opcode compare would treat it as a branch and move the counter instead of raising `foreign_out`.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

   typedef enum logic [1:0] {
      PH_DEC  = 2'd0,
      PH_LIT  = 2'd1,
      PH_PROC = 2'd2,
      PH_WR   = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      BR_NONE  = 2'd0,
      BR_OVCLR = 2'd1,
      BR_ZCLR  = 2'd2
   } br_kind_e;

   localparam int unsigned NUM_OPC = 2;

   // Opcode byte for table entry idx.
   function automatic logic [7:0] opc_code(input int unsigned idx);
      return (idx == 0) ? 8'hE5 : 8'hE1;
   endfunction

   // Branch kind for table entry idx.
   function automatic br_kind_e opc_kind(input int unsigned idx);
      return (idx == 0) ? BR_OVCLR : BR_ZCLR;
   endfunction

endpackage

// File: rtl/cbr_phase_seq.sv
module cbr_phase_seq
   import cbr_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   take_in,
   output phase_e phase,
   output logic   idle
);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_DEC;
         idle  <= 1'b0;
      end else begin
         phase <= phase_e'(phase + 2'd1);
         if (phase == PH_WR) begin
            idle <= idle ? 1'b0 : take_in;
         end
      end
   end

endmodule

// File: rtl/cbr_decode.sv
module cbr_decode
   import cbr_pkg::*;
#(
   parameter int unsigned IW    = 16,
   parameter int unsigned OFF_W = 8
) (
   input  logic [IW-1:0]    word,
   output logic             hit,
   output br_kind_e         kind,
   output logic [OFF_W-1:0] offset
);

   localparam int unsigned OPC_W = IW - OFF_W;

   if (OPC_W != 8) begin : g_bad_opc
      $error("cbr_decode: opcode field must be 8 bits wide");
   end

   logic [NUM_OPC-1:0] match;

   for (genvar gi = 0; gi < NUM_OPC; gi++) begin : g_opc
      assign match[gi] = (word[IW-1 -: OPC_W] == opc_code(gi));
   end

   always_comb begin
      kind = BR_NONE;
      for (int i = 0; i < NUM_OPC; i++) begin
         if (match[i]) kind = opc_kind(i);
      end
   end

   assign hit    = |match;
   assign offset = word[OFF_W-1:0];

endmodule

// File: rtl/cbr_target.sv
module cbr_target #(
   parameter int unsigned PC_W  = 21,
   parameter int unsigned OFF_W = 8
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [OFF_W-1:0] offset,
   output logic [PC_W-1:0]  seq_pc,
   output logic [PC_W-1:0]  tgt
);

   localparam int unsigned EXT_W = PC_W - OFF_W - 1;

   logic [PC_W-1:0] disp;

   if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
   end else begin : g_noext
      assign disp = {offset, 1'b0};
   end

   assign seq_pc = pc + PC_W'(2);
   assign tgt    = seq_pc + disp;

endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
   import cbr_pkg::*;
#(
   parameter int unsigned PC_W  = 21,
   parameter int unsigned IW    = 16,
   parameter int unsigned OFF_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [IW-1:0]   instr_word,
   input  logic            flag_ov,
   input  logic            flag_z,
   output logic [PC_W-1:0] pc_out,
   output logic [1:0]      phase_out,
   output logic            idle_out,
   output logic            taken_out,
   output logic            foreign_out
);

   if (PC_W < OFF_W + 2) begin : g_bad_pc
      $error("cbr_unit: PC_W too narrow for the doubled offset");
   end

   if (IW <= OFF_W) begin : g_bad_iw
      $error("cbr_unit: IW must exceed OFF_W");
   end

   phase_e           phase;
   logic             idle;
   logic [IW-1:0]    ir_q;
   logic             ov_q, z_q;
   logic [OFF_W-1:0] off_q;
   logic             foreign_q, take_q;
   logic [PC_W-1:0]  tgt_q, pc_q;

   logic             hit;
   br_kind_e         kind;
   logic [OFF_W-1:0] offset;
   logic [PC_W-1:0]  seq_pc, tgt;
   logic             cond;

   cbr_phase_seq u_seq (
      .clk     (clk),
      .rst     (rst),
      .take_in (take_q),
      .phase   (phase),
      .idle    (idle)
   );

   cbr_decode #(.IW(IW), .OFF_W(OFF_W)) u_dec (
      .word   (ir_q),
      .hit    (hit),
      .kind   (kind),
      .offset (offset)
   );

   cbr_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
      .pc     (pc_q),
      .offset (off_q),
      .seq_pc (seq_pc),
      .tgt    (tgt)
   );

   always_comb begin
      unique case (kind)
         BR_OVCLR: cond = !ov_q;
         BR_ZCLR:  cond = !z_q;
         default:  cond = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ir_q      <= '0;
         ov_q      <= 1'b0;
         z_q       <= 1'b0;
         off_q     <= '0;
         foreign_q <= 1'b0;
         take_q    <= 1'b0;
         tgt_q     <= '0;
         pc_q      <= '0;
      end else if (!idle) begin
         unique case (phase)
            PH_DEC: begin
               ir_q <= instr_word;
               ov_q <= flag_ov;
               z_q  <= flag_z;
            end
            PH_LIT: begin
               foreign_q <= !hit;
               off_q     <= offset;
            end
            PH_PROC: begin
               take_q <= hit && cond;
               tgt_q  <= tgt;
            end
            PH_WR: begin
               if (!foreign_q) pc_q <= take_q ? tgt_q : seq_pc;
            end
            default: ;
         endcase
      end else begin
         if (phase == PH_LIT)  foreign_q <= 1'b0;
         if (phase == PH_PROC) take_q    <= 1'b0;
      end
   end

   assign pc_out      = pc_q;
   assign phase_out   = phase;
   assign idle_out    = idle;
   assign taken_out   = take_q;
   assign foreign_out = foreign_q;

endmodule

// File: rtl/cbr_unit_chk.sv
module cbr_unit_chk #(
   parameter int unsigned PC_W = 21
) (
   input logic            clk,
   input logic            rst,
   input logic [PC_W-1:0] pc_out,
   input logic [1:0]      phase_out,
   input logic            idle_out,
   input logic            taken_out,
   input logic            foreign_out
);

   // R2
   phase_step_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> phase_out == $past(phase_out) + 2'd1);

   // R9
   pc_even_chk: assert property (@(posedge clk) disable iff (rst)
      !pc_out[0]);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      idle_out |=> $stable(pc_out));

   // R7
   idle_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(idle_out) |-> taken_out);

   // R7
   idle_once_chk: assert property (@(posedge clk) disable iff (rst)
      (idle_out && phase_out == 2'd3) |=> !idle_out);

   // R8
   foreign_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (foreign_out && phase_out == 2'd3) |=> $stable(pc_out));

   // R6
   fall_through_chk: assert property (@(posedge clk) disable iff (rst)
      (!idle_out && !foreign_out && !taken_out && phase_out == 2'd3)
      |=> pc_out == $past(pc_out) + PC_W'(2));

endmodule

bind cbr_unit cbr_unit_chk #(.PC_W(PC_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .pc_out      (pc_out),
   .phase_out   (phase_out),
   .idle_out    (idle_out),
   .taken_out   (taken_out),
   .foreign_out (foreign_out)
);

// File: tb/cbr_unit_tb.sv
module cbr_unit_tb;

   localparam int unsigned PC_W = 21;
   localparam logic [PC_W-1:0] MASK = '1;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [15:0]     instr_word = '0;
   logic            flag_ov = 1'b0;
   logic            flag_z = 1'b0;
   logic [PC_W-1:0] pc_out;
   logic [1:0]      phase_out;
   logic            idle_out, taken_out, foreign_out;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;
   logic [PC_W-1:0] model_pc = '0;

   always #2 clk = ~clk;

   cbr_unit u_dut (
      .clk(clk), .rst(rst), .instr_word(instr_word), .flag_ov(flag_ov),
      .flag_z(flag_z), .pc_out(pc_out), .phase_out(phase_out),
      .idle_out(idle_out), .taken_out(taken_out), .foreign_out(foreign_out)
   );

   // Fields: {word[15:0], ov, z, expected taken, expected foreign}
   localparam int NV = 8;
   localparam logic [19:0] VEC [NV] = '{
      {16'hE510, 1'b0, 1'b1, 1'b1, 1'b0},   // R3 taken, z set ignored
      {16'hE510, 1'b1, 1'b0, 1'b0, 1'b0},   // R3 not taken
      {16'hE1F0, 1'b1, 1'b0, 1'b1, 1'b0},   // R4 taken backwards, ov ignored
      {16'hE105, 1'b0, 1'b1, 1'b0, 1'b0},   // R4 not taken
      {16'hE57F, 1'b0, 1'b0, 1'b1, 1'b0},   // R5 max forward
      {16'h1234, 1'b0, 1'b0, 1'b0, 1'b1},   // R8 foreign
      {16'hE300, 1'b0, 1'b0, 1'b0, 1'b1},   // R8 near-miss opcode
      {16'hE580, 1'b0, 1'b1, 1'b1, 1'b0}    // R5 max backward
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step_phase(input logic [1:0] expect_ph);
      @(posedge clk);
      @(negedge clk);
      chk(phase_out == expect_ph, "R2", 32'(phase_out), 32'(expect_ph));
   endtask

   // Assumes the block is at a negedge in phase 0 and not idle.
   task automatic run_instr(input logic [15:0] w, input bit ov, input bit z,
                            input bit e_take, input bit e_for);
      logic [PC_W-1:0] disp;
      disp = {{(PC_W-9){w[7]}}, w[7:0], 1'b0};
      instr_word = w; flag_ov = ov; flag_z = z;
      step_phase(2'd1);
      instr_word = ~w; flag_ov = ~ov; flag_z = ~z;  // flags only sampled in phase 0
      step_phase(2'd2);
      chk(foreign_out == e_for, "R8", 32'(foreign_out), 32'(e_for));
      step_phase(2'd3);
      chk(taken_out == e_take, "R3/R4 taken", 32'(taken_out), 32'(e_take));
      step_phase(2'd0);
      if (!e_for) model_pc = e_take ? ((model_pc + 2 + disp) & MASK)
                                    : ((model_pc + 2) & MASK);
      chk(pc_out == model_pc, e_take ? "R5" : (e_for ? "R8" : "R6"),
          32'(pc_out), 32'(model_pc));
      chk(pc_out[0] == 1'b0, "R9", 32'(pc_out[0]), 32'd0);
      chk(idle_out == e_take, "R7 idle", 32'(idle_out), 32'(e_take));
      if (e_take) begin
         instr_word = 16'hE500; flag_ov = 1'b0; flag_z = 1'b0;
         for (int k = 1; k <= 4; k++) step_phase(2'(k));
         chk(pc_out == model_pc, "R7 pc held", 32'(pc_out), 32'(model_pc));
         chk(!idle_out && !taken_out && !foreign_out, "R7 after idle",
             {29'd0, idle_out, taken_out, foreign_out}, 32'd0);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(pc_out == '0 && phase_out == 2'd0 && !idle_out && !taken_out && !foreign_out,
          "R1", {pc_out, phase_out, idle_out, taken_out, foreign_out}, 32'd0);
      rst = 1'b0;
      model_pc = '0;
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      for (int i = 0; i < NV; i++) begin
         run_instr(VEC[i][19:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
      end
      // R5 wrap below zero, then R5 wrap past the top
      do_reset();
      run_instr(16'hE180, 1'b1, 1'b0, 1'b1, 1'b0);
      chk(pc_out == 21'h1FFF02, "R5 low wrap", 32'(pc_out), 32'h1FFF02);
      run_instr(16'hE17F, 1'b1, 1'b0, 1'b1, 1'b0);
      chk(pc_out == 21'h000002, "R5 high wrap", 32'(pc_out), 32'h2);
      // R1 reset mid-cycle
      instr_word = 16'hE540; flag_ov = 1'b0;
      @(posedge clk); @(negedge clk);
      do_reset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule